// File: doc/BRIEF.md
# Remote Memory Coherence Filter

This block sits on a compute node's coherent processor link, in front of a memory pool that holds no caches. It accepts coherent transactions: cache-block reads, cache-block writes, invalidations and probes. Each transaction carries an address and a transaction ID. Invalidations and probes are answered on the spot, because there is no cached copy on the far side that could need them. Reads and writes below a configurable boundary address pass unchanged to the node's local memory path. Reads and writes at or above the boundary are turned into a plain command packet for the remote memory. That packet carries a block-aligned address, a 64-byte payload for writes, and a small slot tag in place of the coherent ID.

An outstanding table keeps the requester's ID and the direction of every forwarded request, indexed by slot tag. Remote responses name the slot, may come back in any order, and are turned back into completions that carry the original ID. A write reports completion only when the remote side confirms it. When every slot is busy, further remote requests are held off, while invalidations and probes are still answered.

Top module: `rcf_filter`

## Requirements
- R1: While reset is high and in the first cycle after it, loc_valid, pkt_valid and cpl_valid are 0. A remote read is then ready to be accepted at once, because the outstanding table starts empty.
- R2: A read (req_kind 0) or write (req_kind 1) whose address is at or above cfg_remote_base is forwarded in the cycle after acceptance. pkt_valid is 1, pkt_wr equals bit 0 of the kind, and pkt_addr is the request address with its 6 low bits cleared. For a write, pkt_data is the full 512-bit block.
- R3: A read or write whose address is below cfg_remote_base appears on the local path in the cycle after acceptance, with the same kind bit, address, ID and data. No packet is produced for it.
- R4: An invalidation (req_kind 2) or probe (req_kind 3) at any address is accepted and answered in the next cycle with cpl_kind equal to the request kind and cpl_tid equal to the request ID. It is never forwarded to either memory path.
- R5: A remote response is turned into a completion in the next cycle. A read gives cpl_kind 0 with the response data. A write gives cpl_kind 1 with zero data. In both cases cpl_tid is the ID of the original request.
- R6: Each forwarded request takes the lowest-numbered free slot as its pkt_tag. Responses are matched by tag and may arrive in any order.
- R7: While NOUT remote requests are outstanding, remote reads and writes see req_ready low. Invalidations and probes are still accepted and answered.
- R8: A response and an invalidation or probe can be present in the same cycle. The response is delivered first, and req_ready is low for the invalidation or probe in that cycle.
- R9: While pkt_valid is 1 and pkt_ready is 0, the packet is held with its address and tag unchanged. The local path is held the same way while loc_ready is 0.
- R10: No write completion (cpl_kind 1) is produced for a forwarded write before its remote response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_remote_base | input | AW | Lowest address that belongs to the remote range |
| req_valid | input | 1 | Coherent request present |
| req_ready | output | 1 | Request accepted this cycle when req_valid is also 1 |
| req_kind | input | 2 | 0 read, 1 write, 2 invalidate, 3 probe |
| req_addr | input | AW | Request address |
| req_tid | input | TW | Requester transaction ID |
| req_data | input | 8*BLK_BYTES | Write block data |
| loc_valid | output | 1 | Local memory request valid |
| loc_ready | input | 1 | Local path takes the request |
| loc_wr | output | 1 | Local request is a write |
| loc_addr | output | AW | Local request address |
| loc_tid | output | TW | Local request ID |
| loc_data | output | 8*BLK_BYTES | Local write data |
| pkt_valid | output | 1 | Remote command packet valid |
| pkt_ready | input | 1 | Remote link takes the packet |
| pkt_wr | output | 1 | Packet is a write |
| pkt_addr | output | AW | Block-aligned remote address |
| pkt_tag | output | TAGW | Outstanding slot tag |
| pkt_data | output | 8*BLK_BYTES | Write block (zero for reads) |
| rsp_valid | input | 1 | Remote response present |
| rsp_tag | input | TAGW | Slot tag the response answers |
| rsp_data | input | 8*BLK_BYTES | Read data block |
| cpl_valid | output | 1 | Completion to the requester, one-cycle pulse |
| cpl_kind | output | 2 | 0 read data, 1 write done, 2 invalidate ack, 3 probe ack |
| cpl_tid | output | TW | Transaction ID of the completion |
| cpl_data | output | 8*BLK_BYTES | Read data, zero otherwise |

## Verification
The completion port is shared by two sources: a returning remote response, and the immediate acknowledgement of an invalidation or probe. Both can therefore want it in the same clock. The bench provokes this by raising rsp_valid and a probe request on the same edge. It expects req_ready to be low for the probe in that cycle and the completion to carry the response's ID and data. It then expects the still-pending probe to be acknowledged one cycle later. A second case fills every outstanding slot and checks that invalidations are still answered while remote reads stall.

// File: rtl/rcf_pkg.sv
package rcf_pkg;
  typedef enum logic [1:0] {
    K_READ  = 2'd0,
    K_WRITE = 2'd1,
    K_INVAL = 2'd2,
    K_PROBE = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    C_RDATA  = 2'd0,
    C_WDONE  = 2'd1,
    C_INVACK = 2'd2,
    C_PRBACK = 2'd3
  } cpl_kind_e;
endpackage

// File: rtl/rcf_route.sv
module rcf_route #(
  parameter int AW = 40
) (
  input  logic [1:0]    kind,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  output logic          is_snoop,
  output logic          is_remote,
  output logic          is_wr
);
  import rcf_pkg::*;

  // cache-maintenance kinds share the upper kind bit
  assign is_snoop  = (kind == K_INVAL) || (kind == K_PROBE);
  assign is_remote = (addr >= base);
  assign is_wr     = (kind == K_WRITE);
endmodule

// File: rtl/rcf_outreg.sv
module rcf_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         can_load,
  output logic         valid,
  output logic [W-1:0] dout
);
  assign can_load = !valid || ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  // payload carries no reset so it maps onto plain registers
  always_ff @(posedge clk) begin
    if (load) dout <= din;
  end
endmodule

// File: rtl/rcf_otable.sv
module rcf_otable #(
  parameter int NOUT = 4,
  parameter int TW   = 6,
  parameter int TAGW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            alloc,
  input  logic [TW-1:0]   alloc_tid,
  input  logic            alloc_wr,
  input  logic            free_en,
  input  logic [TAGW-1:0] free_tag,
  output logic            full,
  output logic [TAGW-1:0] alloc_tag,
  output logic [TW-1:0]   rd_tid,
  output logic            rd_wr,
  output logic            rd_live
);
  logic [NOUT-1:0] live;
  logic [TW:0]     meta [NOUT];
  logic            found;

  // lowest free slot wins
  always_comb begin
    alloc_tag = '0;
    found     = 1'b0;
    for (int i = NOUT - 1; i >= 0; i--) begin
      if (!live[i]) begin
        alloc_tag = TAGW'(i);
        found     = 1'b1;
      end
    end
    full = !found;
  end

  // single write port, asynchronous read: small distributed memory
  always_ff @(posedge clk) begin
    if (alloc) meta[alloc_tag] <= {alloc_wr, alloc_tid};
  end

  assign rd_live         = live[free_tag];
  assign {rd_wr, rd_tid} = meta[free_tag];

  always_ff @(posedge clk) begin
    if (rst) begin
      live <= '0;
    end else begin
      if (alloc)              live[alloc_tag] <= 1'b1;
      if (free_en && rd_live) live[free_tag]  <= 1'b0;
    end
  end
endmodule

// File: rtl/rcf_filter.sv
module rcf_filter #(
  parameter int AW        = 40,
  parameter int TW        = 6,
  parameter int NOUT      = 4,
  parameter int BLK_BYTES = 64,
  localparam int DW       = BLK_BYTES * 8,
  localparam int OFFW     = $clog2(BLK_BYTES),
  localparam int TAGW     = (NOUT > 1) ? $clog2(NOUT) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   cfg_remote_base,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_kind,
  input  logic [AW-1:0]   req_addr,
  input  logic [TW-1:0]   req_tid,
  input  logic [DW-1:0]   req_data,
  output logic            loc_valid,
  input  logic            loc_ready,
  output logic            loc_wr,
  output logic [AW-1:0]   loc_addr,
  output logic [TW-1:0]   loc_tid,
  output logic [DW-1:0]   loc_data,
  output logic            pkt_valid,
  input  logic            pkt_ready,
  output logic            pkt_wr,
  output logic [AW-1:0]   pkt_addr,
  output logic [TAGW-1:0] pkt_tag,
  output logic [DW-1:0]   pkt_data,
  input  logic            rsp_valid,
  input  logic [TAGW-1:0] rsp_tag,
  input  logic [DW-1:0]   rsp_data,
  output logic            cpl_valid,
  output logic [1:0]      cpl_kind,
  output logic [TW-1:0]   cpl_tid,
  output logic [DW-1:0]   cpl_data
);
  import rcf_pkg::*;

  localparam int PKT_W = 1 + AW + TAGW + DW;
  localparam int LOC_W = 1 + AW + TW + DW;

  logic            is_snoop, is_remote, is_wr;
  logic            tbl_full, rd_wr, rd_live;
  logic [TAGW-1:0] alloc_tag;
  logic [TW-1:0]   rd_tid;
  logic            pkt_can_load, loc_can_load;
  logic            snoop_go, rem_go, loc_go;
  logic [AW-1:0]   blk_addr;
  logic [PKT_W-1:0] pkt_din, pkt_q;
  logic [LOC_W-1:0] loc_din, loc_q;

  rcf_route #(.AW(AW)) u_route (
    .kind      (req_kind),
    .addr      (req_addr),
    .base      (cfg_remote_base),
    .is_snoop  (is_snoop),
    .is_remote (is_remote),
    .is_wr     (is_wr)
  );

  rcf_otable #(.NOUT(NOUT), .TW(TW), .TAGW(TAGW)) u_tbl (
    .clk       (clk),
    .rst       (rst),
    .alloc     (rem_go),
    .alloc_tid (req_tid),
    .alloc_wr  (is_wr),
    .free_en   (rsp_valid),
    .free_tag  (rsp_tag),
    .full      (tbl_full),
    .alloc_tag (alloc_tag),
    .rd_tid    (rd_tid),
    .rd_wr     (rd_wr),
    .rd_live   (rd_live)
  );

  // acceptance: snoops yield to a returning response, remote traffic
  // needs a free slot and a free packet register, local needs the local register
  always_comb begin
    if (is_snoop)       req_ready = !rsp_valid;
    else if (is_remote) req_ready = !tbl_full && pkt_can_load;
    else                req_ready = loc_can_load;
  end

  assign snoop_go = req_valid && req_ready && is_snoop;
  assign rem_go   = req_valid && req_ready && !is_snoop && is_remote;
  assign loc_go   = req_valid && req_ready && !is_snoop && !is_remote;

  assign blk_addr = {req_addr[AW-1:OFFW], {OFFW{1'b0}}};
  assign pkt_din  = {is_wr, blk_addr, alloc_tag, is_wr ? req_data : {DW{1'b0}}};
  assign loc_din  = {is_wr, req_addr, req_tid, req_data};

  rcf_outreg #(.W(PKT_W)) u_pkt (
    .clk      (clk),
    .rst      (rst),
    .load     (rem_go),
    .din      (pkt_din),
    .ready    (pkt_ready),
    .can_load (pkt_can_load),
    .valid    (pkt_valid),
    .dout     (pkt_q)
  );

  rcf_outreg #(.W(LOC_W)) u_loc (
    .clk      (clk),
    .rst      (rst),
    .load     (loc_go),
    .din      (loc_din),
    .ready    (loc_ready),
    .can_load (loc_can_load),
    .valid    (loc_valid),
    .dout     (loc_q)
  );

  assign {pkt_wr, pkt_addr, pkt_tag, pkt_data} = pkt_q;
  assign {loc_wr, loc_addr, loc_tid, loc_data} = loc_q;

  // completion register: remote response first, then snoop acknowledgement
  always_ff @(posedge clk) begin
    if (rst) begin
      cpl_valid <= 1'b0;
      cpl_kind  <= C_RDATA;
      cpl_tid   <= '0;
      cpl_data  <= '0;
    end else if (rsp_valid && rd_live) begin
      cpl_valid <= 1'b1;
      cpl_kind  <= rd_wr ? C_WDONE : C_RDATA;
      cpl_tid   <= rd_tid;
      cpl_data  <= rd_wr ? {DW{1'b0}} : rsp_data;
    end else if (snoop_go) begin
      cpl_valid <= 1'b1;
      cpl_kind  <= req_kind;
      cpl_tid   <= req_tid;
      cpl_data  <= '0;
    end else begin
      cpl_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rcf_checker.sv
module rcf_checker #(
  parameter int AW   = 40,
  parameter int TW   = 6,
  parameter int NOUT = 4,
  parameter int TAGW = 2
) (
  input logic            clk,
  input logic            rst,
  input logic [AW-1:0]   cfg_remote_base,
  input logic            req_valid,
  input logic            req_ready,
  input logic [1:0]      req_kind,
  input logic [AW-1:0]   req_addr,
  input logic [TW-1:0]   req_tid,
  input logic            loc_valid,
  input logic            loc_ready,
  input logic [AW-1:0]   loc_addr,
  input logic            pkt_valid,
  input logic            pkt_ready,
  input logic [AW-1:0]   pkt_addr,
  input logic [TAGW-1:0] pkt_tag,
  input logic            rsp_valid,
  input logic            cpl_valid,
  input logic [1:0]      cpl_kind,
  input logic [TW-1:0]   cpl_tid
);
  localparam int CW = $clog2(NOUT + 1) + 1;

  logic          rem_acc, loc_acc, snp_acc, rem_cpl;
  logic [CW-1:0] cnt, occ;

  assign snp_acc = req_valid && req_ready && req_kind[1];
  assign rem_acc = req_valid && req_ready && !req_kind[1] && (req_addr >= cfg_remote_base);
  assign loc_acc = req_valid && req_ready && !req_kind[1] && (req_addr < cfg_remote_base);
  assign rem_cpl = cpl_valid && !cpl_kind[1];
  assign occ     = cnt - CW'(rem_cpl);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= occ + CW'(rem_acc);
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> !pkt_valid && !loc_valid && !cpl_valid);

  p_fwd_block_r2: assert property (@(posedge clk) disable iff (rst)
    rem_acc |=> pkt_valid && pkt_addr[5:0] == 6'd0 && pkt_addr[AW-1:6] == $past(req_addr[AW-1:6]));

  p_local_pass_r3: assert property (@(posedge clk) disable iff (rst)
    loc_acc |=> loc_valid && loc_addr == $past(req_addr));

  p_snoop_ack_r4: assert property (@(posedge clk) disable iff (rst)
    snp_acc |=> cpl_valid && cpl_kind == $past(req_kind) && cpl_tid == $past(req_tid));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    occ <= CW'(NOUT));

  p_full_stall_r7: assert property (@(posedge clk) disable iff (rst)
    (occ == CW'(NOUT)) && req_valid && !req_kind[1] && (req_addr >= cfg_remote_base) |-> !req_ready);

  p_rsp_first_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && req_valid && req_kind[1] |-> !req_ready);

  p_pkt_hold_r9: assert property (@(posedge clk) disable iff (rst)
    pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_addr) && $stable(pkt_tag));

  p_loc_hold_r9: assert property (@(posedge clk) disable iff (rst)
    loc_valid && !loc_ready |=> loc_valid && $stable(loc_addr));

  p_wdone_owed_r10: assert property (@(posedge clk) disable iff (rst)
    cpl_valid && cpl_kind == 2'd1 |-> cnt != '0);
endmodule

bind rcf_filter rcf_checker #(.AW(AW), .TW(TW), .NOUT(NOUT), .TAGW(TAGW)) u_chk (.*);

// File: tb/tb_rcf_filter.sv
module tb_rcf_filter;
  localparam int AW = 40, TW = 6, NOUT = 4, DW = 512, TAGW = 2;
  localparam logic [AW-1:0] BASE = 40'h01_0000_0000;

  logic clk = 1'b0, rst = 1'b1;
  logic [AW-1:0] cfg_remote_base = BASE;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_kind = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [TW-1:0] req_tid = '0;
  logic [DW-1:0] req_data = '0;
  logic loc_valid, loc_ready = 1'b1, loc_wr;
  logic [AW-1:0] loc_addr;
  logic [TW-1:0] loc_tid;
  logic [DW-1:0] loc_data;
  logic pkt_valid, pkt_ready = 1'b1, pkt_wr;
  logic [AW-1:0] pkt_addr;
  logic [TAGW-1:0] pkt_tag;
  logic [DW-1:0] pkt_data;
  logic rsp_valid = 1'b0;
  logic [TAGW-1:0] rsp_tag = '0;
  logic [DW-1:0] rsp_data = '0;
  logic cpl_valid;
  logic [1:0] cpl_kind;
  logic [TW-1:0] cpl_tid;
  logic [DW-1:0] cpl_data;

  always #10 clk = ~clk;

  rcf_filter #(.AW(AW), .TW(TW), .NOUT(NOUT), .BLK_BYTES(64)) dut (.*);

  int nchk = 0, nerr = 0;
  bit done = 1'b0;
  logic          m_live [NOUT];
  logic [TW-1:0] m_tid  [NOUT];
  logic          m_wr   [NOUT];

  task automatic chk(input bit ok, input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rnd_blk();
    logic [DW-1:0] v;
    for (int i = 0; i < DW / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic int n_live();
    int n = 0;
    for (int i = 0; i < NOUT; i++) if (m_live[i]) n++;
    return n;
  endfunction

  function automatic int low_free();
    for (int i = 0; i < NOUT; i++) if (!m_live[i]) return i;
    return -1;
  endfunction

  // called just after a falling edge; checks outputs one edge later
  task automatic do_req(input logic [1:0] k, input logic [AW-1:0] a, input logic [TW-1:0] t, input logic [DW-1:0] d);
    logic rdy;
    int tg;
    bit rem;
    rem = (a >= BASE);
    tg  = low_free();
    req_valid = 1'b1; req_kind = k; req_addr = a; req_tid = t; req_data = d;
    #1 rdy = req_ready;
    @(negedge clk);
    req_valid = 1'b0;
    if (k[1]) begin
      // R4: acknowledged next cycle, nothing forwarded
      chk(rdy && cpl_valid && cpl_kind == k && cpl_tid == t && !pkt_valid && !loc_valid, "R4",
          {cpl_valid, cpl_kind, cpl_tid, pkt_valid, loc_valid}, {1'b1, k, t, 2'b00});
    end else if (rem) begin
      if (n_live() == NOUT) begin
        chk(!rdy && !pkt_valid, "R7", {rdy, pkt_valid}, 2'b00);
      end else begin
        // R2 fields, R6 lowest free slot tag
        chk(rdy && pkt_valid && pkt_wr == k[0] && pkt_addr == {a[AW-1:6], 6'd0} && pkt_tag == TAGW'(tg)
            && pkt_data == (k[0] ? d : '0), "R2/R6",
            {pkt_valid, pkt_wr, pkt_addr, pkt_tag}, {1'b1, k[0], a[AW-1:6], 6'd0, TAGW'(tg)});
        m_live[tg] = 1'b1; m_tid[tg] = t; m_wr[tg] = k[0];
      end
    end else begin
      chk(rdy && loc_valid && loc_wr == k[0] && loc_addr == a && loc_tid == t && loc_data == d && !pkt_valid, "R3",
          {loc_valid, loc_wr, loc_addr, loc_tid, pkt_valid}, {1'b1, k[0], a, t, 1'b0});
    end
  endtask

  task automatic do_rsp(input int tg, input logic [DW-1:0] d);
    logic [DW-1:0] ed;
    ed = m_wr[tg] ? '0 : d;
    rsp_valid = 1'b1; rsp_tag = TAGW'(tg); rsp_data = d;
    @(negedge clk);
    rsp_valid = 1'b0;
    // R5: original ID, read data or write-done
    chk(cpl_valid && cpl_kind == {1'b0, m_wr[tg]} && cpl_tid == m_tid[tg] && cpl_data == ed, "R5",
        {cpl_valid, cpl_kind, cpl_tid}, {1'b1, 1'b0, m_wr[tg], m_tid[tg]});
    chk(cpl_data == ed, "R5 data", cpl_data, ed);
    m_live[tg] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    logic rdy;
    void'($urandom(32'h5EED_0001));
    for (int i = 0; i < NOUT; i++) begin m_live[i] = 1'b0; m_tid[i] = '0; m_wr[i] = 1'b0; end
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!pkt_valid && !loc_valid && !cpl_valid, "R1", {pkt_valid, loc_valid, cpl_valid}, 3'b000);
    rst = 1'b0;
    @(negedge clk);
    req_kind = 2'd0; req_addr = BASE;
    #1 chk(req_ready && !pkt_valid && !loc_valid && !cpl_valid, "R1",
           {req_ready, pkt_valid, loc_valid, cpl_valid}, 4'b1000);
    @(negedge clk);

    // R2 read, R2 write; R10 no early write-done
    do_req(2'd0, BASE + 40'h47, 6'd5, '0);
    d = rnd_blk();
    do_req(2'd1, BASE + 40'h1234, 6'd9, d);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!cpl_valid, "R10", cpl_valid, 1'b0);
    end
    // R3 boundary: base-1 local, base remote
    do_req(2'd1, BASE - 40'd1, 6'd3, rnd_blk());
    // R4 invalidate and probe at remote addresses
    do_req(2'd2, BASE + 40'h80, 6'd11, '0);
    do_req(2'd3, BASE + 40'hC0, 6'd12, '0);
    // R6 out of order: write slot first, then read slot
    do_rsp(1, rnd_blk());
    do_rsp(0, rnd_blk());

    // R7 fill the table
    for (int i = 0; i < NOUT; i++) do_req(2'd0, BASE + 40'(i * 64), 6'(20 + i), '0);
    do_req(2'd0, BASE + 40'h1000, 6'd30, '0);
    do_req(2'd1, BASE + 40'h2000, 6'd31, rnd_blk());
    do_req(2'd2, BASE + 40'h40, 6'd32, '0);

    // R8 response and probe in the same cycle
    d = rnd_blk();
    req_valid = 1'b1; req_kind = 2'd3; req_addr = BASE; req_tid = 6'd40;
    rsp_valid = 1'b1; rsp_tag = 2'd2; rsp_data = d;
    #1 rdy = req_ready;
    chk(!rdy, "R8", rdy, 1'b0);
    @(negedge clk);
    rsp_valid = 1'b0;
    chk(cpl_valid && cpl_kind == 2'd0 && cpl_tid == m_tid[2] && cpl_data == d, "R8",
        {cpl_valid, cpl_kind, cpl_tid}, {1'b1, 2'd0, m_tid[2]});
    m_live[2] = 1'b0;
    #1 rdy = req_ready;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rdy && cpl_valid && cpl_kind == 2'd3 && cpl_tid == 6'd40, "R8",
        {rdy, cpl_valid, cpl_kind, cpl_tid}, {1'b1, 1'b1, 2'd3, 6'd40});

    // R9 packet held under back-pressure
    pkt_ready = 1'b0;
    do_req(2'd0, BASE + 40'h5555, 6'd41, '0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(pkt_valid && pkt_addr == (BASE + 40'h5540) && pkt_tag == 2'd2, "R9",
          {pkt_valid, pkt_addr, pkt_tag}, {1'b1, BASE + 40'h5540, 2'd2});
    end
    pkt_ready = 1'b1;
    @(negedge clk);
    chk(!pkt_valid, "R9", pkt_valid, 1'b0);
    // R9 local path held
    loc_ready = 1'b0;
    do_req(2'd0, 40'h0000_4444, 6'd42, '0);
    @(negedge clk);
    chk(loc_valid && loc_addr == 40'h0000_4444, "R9", {loc_valid, loc_addr}, {1'b1, 40'h0000_4444});
    loc_ready = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NOUT; i++) if (m_live[i]) do_rsp(i, rnd_blk());

    // random mix
    for (int n = 0; n < 400; n++) begin
      int k, sel;
      logic [AW-1:0] a;
      k = $urandom % 4;
      a = ($urandom % 2) ? BASE + 40'($urandom) : 40'($urandom);
      if (n_live() > 0 && ($urandom % 3 == 0 || (n_live() == NOUT && $urandom % 2 == 0))) begin
        sel = $urandom % NOUT;
        while (!m_live[sel]) sel = (sel + 1) % NOUT;
        do_rsp(sel, rnd_blk());
      end
      do_req(2'(k), a, 6'($urandom), rnd_blk());
    end
    for (int i = 0; i < NOUT; i++) if (m_live[i]) do_rsp(i, rnd_blk());

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule